// File: doc/BRIEF.md
# Jacobian Point Doubler with Shared Modular ALU

This block doubles an elliptic-curve point held in Jacobian projective coordinates (X, Y, Z) over a prime field. The curve is assumed to be short-Weierstrass with a = −3. A start pulse captures the three input coordinates. A fixed program of eighteen micro-operations then runs over a small register file, and every step uses one modular ALU. That ALU has a one-cycle add/subtract path and an iterative multiplier. A one-cycle done pulse marks the point where the doubled coordinates are ready on the output ports.

The prime `Q` and the stored constant `INV2` (the inverse of two modulo `Q`) are parameters. Halving is done by multiplying by `INV2`. Doubling a value is an add of the operand to itself. A squaring reads the same register on both multiplier inputs, with no copy step. The block does not detect special cases. An input with Z = 0 gives Z = 0 at the output with no extra logic, because the output Z is the product of Z and 2Y.

Top module: `jac_dbl_seq`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and all three outputs read 0 until the first computation writes them.
- R2: After `done`, `out_x` equals M² − 2S mod Q, where M = 3(X − Z²)(X + Z²) and S = X·(2Y)², computed from the captured inputs.
- R3: After `done`, `out_y` equals M·(S − out_x) − (2Y)⁴·INV2 mod Q.
- R4: After `done`, `out_z` equals 2·Y·Z mod Q, so an input with Z = 0 gives `out_z` = 0.
- R5: Every ALU result, and therefore every output, lies in [0, Q) whenever all inputs lie in [0, Q).
- R6: `done` is high for exactly one clock cycle per computation.
- R7: `done` goes high exactly 9·(W+2)+9 rising edges after the edge that samples `start`. The program has nine multiplies of W+2 cycles each and nine single-cycle add/subtract steps.
- R8: A `start` pulse during a running computation is ignored. The result and the latency are those of the computation already in progress.
- R9: After `done` and until the next accepted `start`, the outputs hold their values whatever the inputs do.
- R10: The inputs are sampled only on the edge that accepts `start`. Changes to them afterwards do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a doubling; accepted only when idle |
| in_x | input | W | Input X coordinate, must be below Q |
| in_y | input | W | Input Y coordinate, must be below Q |
| in_z | input | W | Input Z coordinate, must be below Q |
| done | output | 1 | One-cycle pulse when results are valid |
| out_x | output | W | Doubled point X |
| out_y | output | W | Doubled point Y |
| out_z | output | W | Doubled point Z |

## Verification
The bench builds the block with W = 8, Q = 251 and INV2 = 126. In a field this small, every intermediate product fits in an ordinary integer, so the bench works out each expected coordinate with plain modular arithmetic. Over a hundred input triples spread across the field, plus the corners (all zeros, all Q−1, Z = 0, equal coordinates), can each be run at 99 cycles per doubling. The bench also starts a run with a stray start pulse partway through and with inputs changed after capture. It watches the idle hold with the inputs toggling.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2
   } op_e;

   typedef enum logic [3:0] {
      RG_XI  = 4'd0,
      RG_YI  = 4'd1,
      RG_ZI  = 4'd2,
      RG_T1  = 4'd3,
      RG_T2  = 4'd4,
      RG_T3  = 4'd5,
      RG_T4  = 4'd6,
      RG_T5  = 4'd7,
      RG_XO  = 4'd8,
      RG_YO  = 4'd9,
      RG_ZO  = 4'd10,
      RG_HLF = 4'd11
   } reg_e;

   localparam int NUM_REGS  = 12;
   localparam int NUM_STEPS = 18;
   localparam int NUM_MULS  = 9;

   typedef struct packed {
      op_e  op;
      reg_e dst;
      reg_e sa;
      reg_e sb;
   } uop_t;

   function automatic uop_t mk_uop(op_e op, reg_e dst, reg_e sa, reg_e sb);
      uop_t u;
      u.op  = op;
      u.dst = dst;
      u.sa  = sa;
      u.sb  = sb;
      return u;
   endfunction

endpackage

// File: rtl/dbl_rom.sv
module dbl_rom
   import dbl_pkg::*;
#(
   parameter int PCW = 5
) (
   input  logic [PCW-1:0] pc,
   output uop_t           uop
);

   if (PCW < $clog2(NUM_STEPS)) begin : g_bad_pcw
      $error("dbl_rom: PCW too narrow for the program");
   end

   always_comb begin
      case (pc)
         PCW'(0):  uop = mk_uop(OP_MUL, RG_T1, RG_ZI, RG_ZI);
         PCW'(1):  uop = mk_uop(OP_SUB, RG_T2, RG_XI, RG_T1);
         PCW'(2):  uop = mk_uop(OP_ADD, RG_T3, RG_XI, RG_T1);
         PCW'(3):  uop = mk_uop(OP_MUL, RG_T4, RG_T3, RG_T2);
         PCW'(4):  uop = mk_uop(OP_ADD, RG_T1, RG_T4, RG_T4);
         PCW'(5):  uop = mk_uop(OP_ADD, RG_T2, RG_T1, RG_T4);
         PCW'(6):  uop = mk_uop(OP_ADD, RG_YO, RG_YI, RG_YI);
         PCW'(7):  uop = mk_uop(OP_MUL, RG_ZO, RG_ZI, RG_YO);
         PCW'(8):  uop = mk_uop(OP_MUL, RG_T1, RG_YO, RG_YO);
         PCW'(9):  uop = mk_uop(OP_MUL, RG_T3, RG_XI, RG_T1);
         PCW'(10): uop = mk_uop(OP_MUL, RG_T4, RG_T1, RG_T1);
         PCW'(11): uop = mk_uop(OP_MUL, RG_T5, RG_T4, RG_HLF);
         PCW'(12): uop = mk_uop(OP_MUL, RG_T4, RG_T2, RG_T2);
         PCW'(13): uop = mk_uop(OP_ADD, RG_T1, RG_T3, RG_T3);
         PCW'(14): uop = mk_uop(OP_SUB, RG_XO, RG_T4, RG_T1);
         PCW'(15): uop = mk_uop(OP_SUB, RG_T1, RG_T3, RG_XO);
         PCW'(16): uop = mk_uop(OP_MUL, RG_T3, RG_T1, RG_T2);
         PCW'(17): uop = mk_uop(OP_SUB, RG_YO, RG_T3, RG_T5);
         default:  uop = mk_uop(OP_ADD, RG_T1, RG_T1, RG_T1);
      endcase
   end

endmodule

// File: rtl/mod_addsub.sv
module mod_addsub #(
   parameter int           W = 16,
   parameter logic [W-1:0] Q = 16'hFFF1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);

   logic [W:0]   sum_raw;
   logic [W:0]   sum_red;
   logic [W-1:0] dif_raw;

   always_comb begin
      sum_raw = {1'b0, a} + {1'b0, b};
      sum_red = sum_raw - {1'b0, Q};
      dif_raw = a - b;
      if (sub) begin
         // a-b+Q taken modulo 2^W gives the true residue when a < b
         y = (a >= b) ? dif_raw : dif_raw + Q;
      end else begin
         y = (sum_raw >= {1'b0, Q}) ? sum_red[W-1:0] : sum_raw[W-1:0];
      end
   end

endmodule

// File: rtl/mod_mul.sv
module mod_mul #(
   parameter int           W = 16,
   parameter logic [W-1:0] Q = 16'hFFF1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         done,
   output logic [W-1:0] p
);

   localparam int CW = $clog2(W + 1);

   logic [W-1:0] acc;
   logic [W-1:0] mcand;
   logic [W-1:0] mplier;
   logic [CW-1:0] cnt;
   logic          busy;

   logic [W:0]   dbl_raw;
   logic [W:0]   dbl_red;
   logic [W:0]   add_raw;
   logic [W:0]   add_red;

   always_comb begin
      dbl_raw = {acc, 1'b0};
      dbl_red = (dbl_raw >= {1'b0, Q}) ? dbl_raw - {1'b0, Q} : dbl_raw;
      add_raw = dbl_red + (mplier[W-1] ? {1'b0, mcand} : '0);
      add_red = (add_raw >= {1'b0, Q}) ? add_raw - {1'b0, Q} : add_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         mcand  <= '0;
         mplier <= '0;
         cnt    <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            acc    <= '0;
            mcand  <= a;
            mplier <= b;
            cnt    <= CW'(W);
            busy   <= 1'b1;
         end else if (busy) begin
            acc    <= add_red[W-1:0];
            mplier <= {mplier[W-2:0], 1'b0};
            cnt    <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign p = acc;

   assert_mul_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (p < Q));

   assert_mul_go_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);

endmodule

// File: rtl/jac_dbl_seq.sv
module jac_dbl_seq
   import dbl_pkg::*;
#(
   parameter int           W    = 16,
   parameter logic [W-1:0] Q    = 16'hFFF1,
   parameter logic [W-1:0] INV2 = W'(({1'b0, Q} + 1'b1) >> 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] in_x,
   input  logic [W-1:0] in_y,
   input  logic [W-1:0] in_z,
   output logic         done,
   output logic [W-1:0] out_x,
   output logic [W-1:0] out_y,
   output logic [W-1:0] out_z
);

   localparam int PCW = $clog2(NUM_STEPS);

   if (W < 3) begin : g_bad_w
      $error("jac_dbl_seq: W must be at least 3");
   end
   if (Q[0] == 1'b0 || Q < 3) begin : g_bad_q
      $error("jac_dbl_seq: Q must be an odd prime of at least 3");
   end
   if (((({1'b0, INV2}) << 1) % {1'b0, Q}) != 1) begin : g_bad_inv
      $error("jac_dbl_seq: INV2 is not the inverse of two modulo Q");
   end

   typedef enum logic [1:0] {S_IDLE, S_EXEC, S_MWAIT, S_DONE} st_e;

   st_e            state;
   logic [PCW-1:0] pc;
   uop_t           uop;
   logic [W-1:0]   rf [NUM_REGS];
   logic [W-1:0]   opa;
   logic [W-1:0]   opb;
   logic [W-1:0]   alu_y;
   logic [W-1:0]   mul_p;
   logic           mul_done;
   logic           mul_go;
   logic           wr_en;
   logic [W-1:0]   wr_data;
   logic           load;
   logic           last;

   dbl_rom #(.PCW(PCW)) u_rom (
      .pc  (pc),
      .uop (uop)
   );

   assign opa = rf[uop.sa];
   assign opb = rf[uop.sb];

   mod_addsub #(.W(W), .Q(Q)) u_addsub (
      .a   (opa),
      .b   (opb),
      .sub (uop.op == OP_SUB),
      .y   (alu_y)
   );

   assign mul_go = (state == S_EXEC) && (uop.op == OP_MUL);

   mod_mul #(.W(W), .Q(Q)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (mul_go),
      .a     (opa),
      .b     (opb),
      .done  (mul_done),
      .p     (mul_p)
   );

   assign load    = (state == S_IDLE) && start;
   assign last    = (pc == PCW'(NUM_STEPS - 1));
   assign wr_en   = ((state == S_EXEC) && (uop.op != OP_MUL)) ||
                    ((state == S_MWAIT) && mul_done);
   assign wr_data = (state == S_MWAIT) ? mul_p : alu_y;

   // register file: the halving constant is a fixed entry, the rest are flops
   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_rf
      if (gi == int'(RG_HLF)) begin : g_const
         assign rf[gi] = INV2;
      end else begin : g_flop
         logic         ld_en;
         logic [W-1:0] ld_val;
         if (gi == int'(RG_XI)) begin : g_lx
            assign ld_en  = load;
            assign ld_val = in_x;
         end else if (gi == int'(RG_YI)) begin : g_ly
            assign ld_en  = load;
            assign ld_val = in_y;
         end else if (gi == int'(RG_ZI)) begin : g_lz
            assign ld_en  = load;
            assign ld_val = in_z;
         end else begin : g_nold
            assign ld_en  = 1'b0;
            assign ld_val = '0;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rf[gi] <= '0;
            end else if (ld_en) begin
               rf[gi] <= ld_val;
            end else if (wr_en && (uop.dst == reg_e'(gi))) begin
               rf[gi] <= wr_data;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         pc    <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  pc    <= '0;
                  state <= S_EXEC;
               end
            end
            S_EXEC: begin
               if (uop.op == OP_MUL) begin
                  state <= S_MWAIT;
               end else if (last) begin
                  state <= S_DONE;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            S_MWAIT: begin
               if (mul_done) begin
                  if (last) begin
                     state <= S_DONE;
                  end else begin
                     pc    <= pc + 1'b1;
                     state <= S_EXEC;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign done  = (state == S_DONE);
   assign out_x = rf[RG_XO];
   assign out_y = rf[RG_YO];
   assign out_z = rf[RG_ZO];

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && !start) |=> ($stable(out_x) && $stable(out_y) && $stable(out_z)));

   assert_alu_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_EXEC && uop.op != OP_MUL) |-> (alu_y < Q));

   assert_wait_on_mul_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MWAIT) |-> (uop.op == OP_MUL));

endmodule

// File: tb/tb_jac_dbl_seq.sv
module tb_jac_dbl_seq;

   localparam int CLK_PERIOD = 10;
   localparam int W    = 8;
   localparam int QI   = 251;
   localparam int HI   = 126;
   localparam int LAT  = 9 * (W + 2) + 9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] in_x = '0;
   logic [W-1:0] in_y = '0;
   logic [W-1:0] in_z = '0;
   logic         done;
   logic [W-1:0] out_x;
   logic [W-1:0] out_y;
   logic [W-1:0] out_z;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   jac_dbl_seq #(.W(W), .Q(8'd251), .INV2(8'd126)) dut (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .in_x  (in_x),
      .in_y  (in_y),
      .in_z  (in_z),
      .done  (done),
      .out_x (out_x),
      .out_y (out_y),
      .out_z (out_z)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int md(input int v);
      return ((v % QI) + QI) % QI;
   endfunction

   task automatic model(input int x, input int y, input int z,
                        output int ex, output int ey, output int ez);
      int zz, m, y2, s, y4, hh;
      zz = md(z * z);
      m  = md(3 * md(md(x - zz) * md(x + zz)));
      y2 = md(2 * y);
      s  = md(x * md(y2 * y2));
      y4 = md(md(y2 * y2) * md(y2 * y2));
      hh = md(y4 * HI);
      ez = md(y2 * z);
      ex = md(m * m - 2 * s);
      ey = md(m * md(s - ex) - hh);
   endtask

   // poke >= 0: pulse start with other inputs that many edges into the run
   task automatic run_op(input int x, input int y, input int z, input int poke,
                         output int lat);
      @(negedge clk);
      in_x  = W'(x);
      in_y  = W'(y);
      in_z  = W'(z);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      in_x  = W'(md(x + 77));
      in_y  = W'(md(y + 13));
      in_z  = W'(md(z + 101));
      lat = 0;
      while (!done && lat < 5000) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat == poke) begin
            start = 1'b1;
            in_x  = W'(md(x + 3));
            in_y  = W'(md(y + 5));
            in_z  = W'(md(z + 7));
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
   endtask

   task automatic full_check(input int x, input int y, input int z, input int poke,
                             input bit tag10);
      int lat, ex, ey, ez;
      run_op(x, y, z, poke, lat);
      model(x, y, z, ex, ey, ez);
      if (tag10) begin
         check("R10 x after input change", int'(out_x), ex);
      end else if (poke >= 0) begin
         check("R8 x with stray start", int'(out_x), ex);
         check("R8 latency with stray start", lat, LAT);
      end else begin
         check("R2 out_x", int'(out_x), ex);
      end
      check("R3 out_y", int'(out_y), ey);
      check("R4 out_z", int'(out_z), ez);
      check("R5 range", int'((out_x < QI) && (out_y < QI) && (out_z < QI)), 1);
      check("R7 latency", lat, LAT);
      @(negedge clk);
      check("R6 done single", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int ex, ey, ez;
      repeat (3) @(negedge clk);
      check("R1 done in reset", int'(done), 0);
      check("R1 out_x in reset", int'(out_x), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 done after reset", int'(done), 0);
      check("R1 outputs after reset", int'(out_x) + int'(out_y) + int'(out_z), 0);

      // corners
      full_check(0, 0, 0, -1, 0);
      full_check(QI - 1, QI - 1, QI - 1, -1, 0);
      full_check(1, 0, 1, -1, 0);
      full_check(7, 7, 7, -1, 0);
      full_check(1, 1, 1, -1, 0);

      // Z = 0 always yields out_z = 0 (R4)
      for (int i = 0; i < 6; i++) begin
         int lat;
         run_op(md(i * 41 + 3), md(i * 29 + 8), 0, -1, lat);
         check("R4 zero Z", int'(out_z), 0);
         @(negedge clk);
      end

      // sweep across the field
      for (int i = 0; i < 110; i++) begin
         full_check(md(i * 37 + 5), md(i * 91 + 17), md(i * 53 + 2), -1, 0);
      end

      // stray start pulses during the run (R8)
      full_check(100, 200, 50, 1, 0);
      full_check(33, 44, 55, 20, 0);
      full_check(250, 3, 9, LAT - 1, 0);

      // inputs changed after capture (R10)
      full_check(12, 34, 56, -1, 1);

      // hold after done (R9)
      model(md(250 * 37 + 5), md(250 * 91 + 17), md(250 * 53 + 2), ex, ey, ez);
      full_check(md(250 * 37 + 5), md(250 * 91 + 17), md(250 * 53 + 2), -1, 0);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         in_x = W'(k * 7);
         in_y = W'(k * 3);
         in_z = W'(k * 5);
      end
      check("R9 hold x", int'(out_x), ex);
      check("R9 hold y", int'(out_y), ey);
      check("R9 hold z", int'(out_z), ez);
      check("R6 done stays low when idle", int'(done), 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule